// File: doc/BRIEF.md
# Tile Row Float Narrowing Packer

This block takes one row of a two-dimensional tile of 32-bit words and returns a 64-byte slice of that row. Each of the 16 words in the slice is read as a single-precision float and narrowed to a 16-bit float. A control bit picks the target format: brain-float (8-bit exponent) or IEEE half precision (5-bit exponent). A second control bit picks which half of each 32-bit output lane receives the narrowed value. The other half is cleared.

A 32-bit selector picks the row and the slice. The block drives the row index on a read port toward the tile storage, which sits outside this block, and receives the whole row back on the following cycle. A column byte width input sets how many words of the row hold data. Lanes at or past that width produce zero. Both conversions round to nearest, with ties going to even.

Top module: `tile_row_narrow`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: When `start` is high at a rising edge, `rd_row` carries `sel[15:0]` from the next cycle on, and `rd_data` must return that row during that cycle. The result appears with `out_valid` high for exactly one cycle, starting at the second rising edge after the `start` edge. A `start` on every cycle gives one result per cycle.
- R3: `sel[15:0]` is the row index and `sel[31:16]` is the slice number. Lane i of the output is taken from word `slice*16 + i` of the row, where word j occupies `rd_data[32j+31:32j]`.
- R4: In brain-float mode (`fmt_half`=0), a non-NaN input keeps its upper 16 bits, rounded to nearest-even on the lower 16 bits. Values at the top of the finite range may round up to infinity.
- R5: In brain-float mode, any NaN input gives `{sign, 15'h7FC0}`, and an infinity stays an infinity of the same sign.
- R6: In half mode (`fmt_half`=1), normal results are rounded to nearest-even on the 13 discarded mantissa bits. A carry out of the mantissa raises the exponent.
- R7: In half mode, an input of magnitude 65520 or more gives a signed infinity (`0x7C00`). Any NaN input gives `{sign, 15'h7E00}`.
- R8: In half mode, inputs below 2^-14 in magnitude give correctly rounded subnormals (nearest-even) or a signed zero. Single-precision subnormal inputs give signed zero.
- R9: With `place_hi`=1, the narrowed value sits in bits 31:16 of its lane and bits 15:0 are zero. With `place_hi`=0, it sits in bits 15:0 and bits 31:16 are zero.
- R10: A lane whose source word index is at least `floor(colsb/4)`, or lies past the row width, outputs a full zero word in both halves.
- R11: `sel`, `colsb`, `fmt_half` and `place_hi` are sampled only on the `start` edge. Later changes do not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one extraction |
| sel | input | 32 | Row index (15:0) and slice number (31:16) |
| colsb | input | 16 | Valid column width of the tile in bytes |
| fmt_half | input | 1 | 0 = brain-float target, 1 = IEEE half target |
| place_hi | input | 1 | 1 = value in upper half of each lane, 0 = lower half |
| rd_row | output | 16 | Row index presented to the tile storage |
| rd_data | input | ROW_BYTES*8 | Row returned by the tile storage |
| out_valid | output | 1 | Result valid pulse |
| out_data | output | LANES*32 | Packed narrowed lanes |

## Verification
The hardest cases to reach are the rounding boundaries. These are exact ties with even and odd retained bits, the step from the largest finite half value to infinity, and the band where half results go subnormal or vanish to zero. Random floats almost never land on them. The bench therefore fills one stored row with 32 hand-chosen bit patterns, each with a precomputed result in both formats. It then sweeps that row through both slices, both formats and both placements. Column widths that are not a multiple of four, and slice numbers past the row end, exercise the masking.

// File: rtl/tnp_pkg.sv
package tnp_pkg;

  // Narrow single precision to brain-float, ties to even, NaN canonicalised.
  function automatic logic [15:0] narrow_bf16(input logic [31:0] x);
    logic up;
    if (x[30:23] == 8'hFF && x[22:0] != 23'h0) begin
      return {x[31], 15'h7FC0};
    end
    up = x[15] & ((|x[14:0]) | x[16]);
    return x[31:16] + {15'h0, up};
  endfunction

  // Narrow single precision to IEEE half, ties to even, with subnormals.
  function automatic logic [15:0] narrow_fp16(input logic [31:0] x);
    logic        s;
    logic [7:0]  e;
    logic [22:0] m;
    logic [24:0] sig;
    logic [24:0] low_mask;
    logic [7:0]  sh;
    logic [10:0] q;
    logic        g;
    logic        st;
    logic        up;
    logic [14:0] mag;
    s = x[31];
    e = x[30:23];
    m = x[22:0];
    mag = 15'h0;
    if (e == 8'hFF) begin
      mag = (m != 23'h0) ? 15'h7E00 : 15'h7C00;
    end else if (e >= 8'd143) begin
      mag = 15'h7C00;
    end else if (e >= 8'd113) begin
      g   = m[12];
      st  = |m[11:0];
      up  = g & (st | m[13]);
      mag = {5'(e - 8'd112), m[22:13]} + {14'h0, up};
    end else begin
      sh = 8'd126 - e;
      if (sh <= 8'd25) begin
        sig      = {2'b01, m};
        q        = 11'(sig >> sh);
        g        = sig[5'(sh - 8'd1)];
        low_mask = (25'd1 << (sh - 8'd1)) - 25'd1;
        st       = |(sig & low_mask);
        up       = g & (st | q[0]);
        mag      = {4'h0, q} + {14'h0, up};
      end
    end
    return {s, mag};
  endfunction

endpackage

// File: rtl/tnp_lane_narrow.sv
module tnp_lane_narrow
  import tnp_pkg::*;
(
  input  logic [31:0] src,
  input  logic        ok,
  input  logic        fmt_half,
  input  logic        place_hi,
  output logic [31:0] word,
  output logic        nan_flag,
  output logic        ovf_flag
);
  logic [15:0] narrowed;

  assign nan_flag = (src[30:23] == 8'hFF) && (src[22:0] != 23'h0);
  // magnitude that cannot fit a finite half value (infinity included)
  assign ovf_flag = (src[30:23] >= 8'd143) && !nan_flag;

  always_comb begin
    narrowed = fmt_half ? narrow_fp16(src) : narrow_bf16(src);
    if (!ok)            word = 32'h0;
    else if (place_hi)  word = {narrowed, 16'h0};
    else                word = {16'h0, narrowed};
  end
endmodule

// File: rtl/tnp_chunk_pick.sv
module tnp_chunk_pick #(
  parameter int ROW_BYTES = 128,
  parameter int LANES     = 16
) (
  input  logic [ROW_BYTES*8-1:0] row_data,
  input  logic [15:0]            chunk,
  input  logic [15:0]            colsb,
  output logic [LANES*32-1:0]    lane_src,
  output logic [LANES-1:0]       lane_ok
);
  localparam int ROW_DWORDS = ROW_BYTES / 4;
  localparam int RW         = $clog2(ROW_DWORDS);
  localparam int LSH        = $clog2(LANES);
  localparam int IDX_W      = 16 + LSH + 1;

  logic [IDX_W-1:0] limit;
  assign limit = IDX_W'(colsb >> 2);

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    logic [IDX_W-1:0] idx;
    assign idx = (IDX_W'(chunk) << LSH) + IDX_W'(i);
    assign lane_ok[i] = (idx < limit) && (idx < IDX_W'(ROW_DWORDS));
    assign lane_src[32*i +: 32] = lane_ok[i] ? row_data[32*idx[RW-1:0] +: 32] : 32'h0;
  end
endmodule

// File: rtl/tile_row_narrow.sv
module tile_row_narrow #(
  parameter int ROW_BYTES = 128,
  parameter int LANES     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            sel,
  input  logic [15:0]            colsb,
  input  logic                   fmt_half,
  input  logic                   place_hi,
  output logic [15:0]            rd_row,
  input  logic [ROW_BYTES*8-1:0] rd_data,
  output logic                   out_valid,
  output logic [LANES*32-1:0]    out_data
);
  localparam int OUT_W = LANES * 32;

  // capture stage: everything sampled on the start edge
  logic        a_vld;
  logic [15:0] row_q;
  logic [15:0] chunk_q;
  logic [15:0] colsb_q;
  logic        fmt_q;
  logic        hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld   <= 1'b0;
      row_q   <= 16'h0;
      chunk_q <= 16'h0;
      colsb_q <= 16'h0;
      fmt_q   <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      a_vld <= start;
      if (start) begin
        row_q   <= sel[15:0];
        chunk_q <= sel[31:16];
        colsb_q <= colsb;
        fmt_q   <= fmt_half;
        hi_q    <= place_hi;
      end
    end
  end

  assign rd_row = row_q;

  logic [OUT_W-1:0] lane_src;
  logic [LANES-1:0] lane_ok;
  logic [OUT_W-1:0] lane_word;
  logic [LANES-1:0] nan_flag;
  logic [LANES-1:0] ovf_flag;

  tnp_chunk_pick #(.ROW_BYTES(ROW_BYTES), .LANES(LANES)) u_pick (
    .row_data (rd_data),
    .chunk    (chunk_q),
    .colsb    (colsb_q),
    .lane_src (lane_src),
    .lane_ok  (lane_ok)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tnp_lane_narrow u_lane (
      .src      (lane_src[32*i +: 32]),
      .ok       (lane_ok[i]),
      .fmt_half (fmt_q),
      .place_hi (hi_q),
      .word     (lane_word[32*i +: 32]),
      .nan_flag (nan_flag[i]),
      .ovf_flag (ovf_flag[i])
    );
  end

  // result stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= a_vld;
      if (a_vld) out_data <= lane_word;
    end
  end

  // R2
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 out_valid);
  // R2
  no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_vld |=> !out_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R10
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && !lane_ok[i]) |=> (out_data[32*i +: 32] == 32'h0));
    // R9
    place_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && hi_q) |=> (out_data[32*i +: 16] == 16'h0));
    // R9
    place_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && !hi_q) |=> (out_data[32*i+16 +: 16] == 16'h0));
    // R5
    bf_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && !fmt_q && lane_ok[i] && nan_flag[i] && hi_q)
        |=> ((&out_data[32*i+23 +: 8]) && (|out_data[32*i+16 +: 7])));
    // R7
    hf_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && fmt_q && lane_ok[i] && ovf_flag[i] && !hi_q)
        |=> (out_data[32*i +: 15] == 15'h7C00));
  end
endmodule

// File: tb/tb_tile_row_narrow.sv
module tb_tile_row_narrow;
  localparam int ROW_BYTES = 128;
  localparam int LANES     = 16;
  localparam int NW        = ROW_BYTES / 4;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic [31:0]            sel = 32'h0;
  logic [15:0]            colsb = 16'h0;
  logic                   fmt_half = 1'b0;
  logic                   place_hi = 1'b0;
  logic [15:0]            rd_row;
  logic [ROW_BYTES*8-1:0] rd_data;
  logic                   out_valid;
  logic [LANES*32-1:0]    out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] vec [NW];
  logic [15:0] xbf [NW];
  logic [15:0] xhf [NW];

  // 4 time units per cycle (250 MHz at 1 ns units)
  always #2 clk = ~clk;

  tile_row_narrow #(.ROW_BYTES(ROW_BYTES), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .colsb(colsb),
    .fmt_half(fmt_half), .place_hi(place_hi), .rd_row(rd_row),
    .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data)
  );

  // tile storage model: row 0 test vectors, row 3 all 3.0, others all -1.0
  function automatic logic [31:0] stored(input logic [15:0] r, input int j);
    if (r == 16'd0) return vec[j];
    if (r == 16'd3) return 32'h40400000;
    return 32'hBF800000;
  endfunction

  always_comb begin
    for (int j = 0; j < NW; j++) rd_data[32*j +: 32] = stored(rd_row, j);
  end

  function automatic logic [15:0] want_half(input int r, input int j, input bit f);
    if (r == 0) return f ? xhf[j] : xbf[j];
    if (r == 3) return f ? 16'h4200 : 16'h4040;
    return f ? 16'hBC00 : 16'hBF80;
  endfunction

  function automatic logic [31:0] want_word(input int r, input int ch, input int cb,
                                            input bit f, input bit h, input int lane);
    int idx;
    logic [15:0] v;
    idx = ch * LANES + lane;
    if (idx >= cb / 4 || idx >= NW) return 32'h0;
    v = want_half(r, idx, f);
    return h ? {v, 16'h0} : {16'h0, v};
  endfunction

  task automatic chk(input bit cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input int r, input int ch, input int cb, input bit f, input bit h);
    @(negedge clk);
    start = 1'b1; sel = {16'(ch), 16'(r)}; colsb = 16'(cb); fmt_half = f; place_hi = h;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called right after launch: one cycle after the start edge
  task automatic collect(input int r, input int ch, input int cb, input bit f,
                         input bit h, input string req);
    chk(out_valid == 1'b0, "R2", 32'(out_valid), 32'h0, "valid early");
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", 32'(out_valid), 32'h1, "valid at latency");
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] e;
      e = want_word(r, ch, cb, f, h, i);
      chk(out_data[32*i +: 32] == e, req, out_data[32*i +: 32], e, $sformatf("lane %0d", i));
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", 32'(out_valid), 32'h0, "valid pulse width");
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 32'h0, "reset valid");
    chk(out_data == '0, "R1", out_data[31:0], 32'h0, "reset data");
  endtask

  task automatic t_bf16();
    launch(0, 0, 128, 1'b0, 1'b1); collect(0, 0, 128, 1'b0, 1'b1, "R4 R5 R9 R3");
    launch(0, 1, 128, 1'b0, 1'b0); collect(0, 1, 128, 1'b0, 1'b0, "R4 R5 R9 R3");
  endtask

  task automatic t_fp16();
    launch(0, 0, 128, 1'b1, 1'b1); collect(0, 0, 128, 1'b1, 1'b1, "R6 R7 R8 R9");
    launch(0, 0, 128, 1'b1, 1'b0); collect(0, 0, 128, 1'b1, 1'b0, "R6 R7 R8 R9");
    launch(0, 1, 128, 1'b1, 1'b1); collect(0, 1, 128, 1'b1, 1'b1, "R6 R7 R8 R3");
  endtask

  task automatic t_mask();
    launch(0, 0, 30, 1'b1, 1'b1);  collect(0, 0, 30, 1'b1, 1'b1, "R10");
    launch(0, 1, 82, 1'b0, 1'b0);  collect(0, 1, 82, 1'b0, 1'b0, "R10");
    launch(0, 2, 65535, 1'b0, 1'b1); collect(0, 2, 65535, 1'b0, 1'b1, "R10 past row");
    launch(0, 65535, 65535, 1'b1, 1'b0); collect(0, 65535, 65535, 1'b1, 1'b0, "R10 far slice");
    launch(3, 0, 3, 1'b0, 1'b1);   collect(3, 0, 3, 1'b0, 1'b1, "R10 width under one word");
  endtask

  task automatic t_rows();
    launch(3, 0, 64, 1'b0, 1'b1); collect(3, 0, 64, 1'b0, 1'b1, "R3 row three");
    launch(5, 1, 128, 1'b1, 1'b0); collect(5, 1, 128, 1'b1, 1'b0, "R3 row five");
  endtask

  task automatic t_sample();
    launch(0, 0, 128, 1'b1, 1'b0);
    sel = {16'd1, 16'd5}; colsb = 16'd4; fmt_half = 1'b0; place_hi = 1'b1;
    collect(0, 0, 128, 1'b1, 1'b0, "R11");
  endtask

  task automatic t_b2b();
    @(negedge clk);
    start = 1'b1; sel = 32'h0000_0003; colsb = 16'd128; fmt_half = 1'b0; place_hi = 1'b0;
    @(negedge clk);
    sel = 32'h0000_0000; fmt_half = 1'b1; place_hi = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid == 1'b1, "R2", 32'(out_valid), 32'h1, "b2b first valid");
    chk(out_data[31:0] == want_word(3, 0, 128, 1'b0, 1'b0, 0), "R2",
        out_data[31:0], want_word(3, 0, 128, 1'b0, 1'b0, 0), "b2b first");
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", 32'(out_valid), 32'h1, "b2b second valid");
    chk(out_data[63:32] == want_word(0, 0, 128, 1'b1, 1'b1, 1), "R2",
        out_data[63:32], want_word(0, 0, 128, 1'b1, 1'b1, 1), "b2b second");
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", 32'(out_valid), 32'h0, "b2b end");
  endtask

  initial begin
    vec[0]  = 32'h3F800000; xbf[0]  = 16'h3F80; xhf[0]  = 16'h3C00;
    vec[1]  = 32'h3F808000; xbf[1]  = 16'h3F80; xhf[1]  = 16'h3C04;
    vec[2]  = 32'h3F818000; xbf[2]  = 16'h3F82; xhf[2]  = 16'h3C0C;
    vec[3]  = 32'h3F808001; xbf[3]  = 16'h3F81; xhf[3]  = 16'h3C04;
    vec[4]  = 32'h3F801000; xbf[4]  = 16'h3F80; xhf[4]  = 16'h3C00;
    vec[5]  = 32'h3F803000; xbf[5]  = 16'h3F80; xhf[5]  = 16'h3C02;
    vec[6]  = 32'h3F801001; xbf[6]  = 16'h3F80; xhf[6]  = 16'h3C01;
    vec[7]  = 32'h477FE000; xbf[7]  = 16'h4780; xhf[7]  = 16'h7BFF;
    vec[8]  = 32'h477FF000; xbf[8]  = 16'h4780; xhf[8]  = 16'h7C00;
    vec[9]  = 32'h49742400; xbf[9]  = 16'h4974; xhf[9]  = 16'h7C00;
    vec[10] = 32'h38800000; xbf[10] = 16'h3880; xhf[10] = 16'h0400;
    vec[11] = 32'h38000000; xbf[11] = 16'h3800; xhf[11] = 16'h0200;
    vec[12] = 32'h33800000; xbf[12] = 16'h3380; xhf[12] = 16'h0001;
    vec[13] = 32'h33000000; xbf[13] = 16'h3300; xhf[13] = 16'h0000;
    vec[14] = 32'hB3000001; xbf[14] = 16'hB300; xhf[14] = 16'h8001;
    vec[15] = 32'h33400000; xbf[15] = 16'h3340; xhf[15] = 16'h0001;
    vec[16] = 32'h32800000; xbf[16] = 16'h3280; xhf[16] = 16'h0000;
    vec[17] = 32'h7F800001; xbf[17] = 16'h7FC0; xhf[17] = 16'h7E00;
    vec[18] = 32'hFFC12345; xbf[18] = 16'hFFC0; xhf[18] = 16'hFE00;
    vec[19] = 32'hFF800000; xbf[19] = 16'hFF80; xhf[19] = 16'hFC00;
    vec[20] = 32'hC0000000; xbf[20] = 16'hC000; xhf[20] = 16'hC000;
    vec[21] = 32'h7F7FFFFF; xbf[21] = 16'h7F80; xhf[21] = 16'h7C00;
    vec[22] = 32'hC0200000; xbf[22] = 16'hC020; xhf[22] = 16'hC100;
    vec[23] = 32'h00000000; xbf[23] = 16'h0000; xhf[23] = 16'h0000;
    vec[24] = 32'h80000000; xbf[24] = 16'h8000; xhf[24] = 16'h8000;
    vec[25] = 32'h00400000; xbf[25] = 16'h0040; xhf[25] = 16'h0000;
    vec[26] = 32'h3F7FFFFF; xbf[26] = 16'h3F80; xhf[26] = 16'h3C00;
    vec[27] = 32'h3F80C000; xbf[27] = 16'h3F81; xhf[27] = 16'h3C06;
    vec[28] = 32'h7F800000; xbf[28] = 16'h7F80; xhf[28] = 16'h7C00;
    vec[29] = 32'h40490FDB; xbf[29] = 16'h4049; xhf[29] = 16'h4248;
    vec[30] = 32'h47800000; xbf[30] = 16'h4780; xhf[30] = 16'h7C00;
    vec[31] = 32'h387FC000; xbf[31] = 16'h3880; xhf[31] = 16'h03FF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bf16();
    t_fp16();
    t_mask();
    t_rows();
    t_sample();
    t_b2b();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule